// File: doc/BRIEF.md
# Overload Hiccup Fault Sequencer

This block supervises the power stage of a switching step-down converter controller. On every system clock it compares a digitized feedback code with a digitized reference code and looks at the cycle-by-cycle current-limit flag. The fault condition is current limiting while feedback sits below seventy percent of the reference. If that condition holds without a break for a programmable number of system clocks, the sequencer shuts the converter down. It then keeps the power stage off for a fixed number of switching periods and opens a timed restart window.

While the block is shut down it asserts three commands: disable both switches, clamp the compensation node low, and discharge the soft-start node. The off time and the restart window are counted in switching-cycle ticks that come from the PWM oscillator. The window that follows power-up is counted the same way. Fault detection is blanked during the power-up window and during every restart window. At the end of a restart window the block checks the fault condition once. If the fault is still present, it starts another off period. If not, it returns to normal regulation.

Dropping the enable input returns the block to idle at once, with no clock needed.

Top module: `hiccup_seq`

## Requirements
- R1: While `rst_n` or `en` is low, the block is idle: `state_o` is 0 and `stage_off`, `comp_clamp` and `ss_discharge` are all 1. A falling `en` takes effect without waiting for a clock edge.
- R2: The state codes are 0 idle, 1 power-up, 2 run, 3 off and 4 restart. Once `rst_n` and `en` are both high, the internal reset is released on the second clock edge. The block moves from idle to power-up on the next edge.
- R3: Power-up lasts START_TICKS ticks and then moves to run. The fault condition has no effect during power-up. The three shutdown outputs are 0 in power-up.
- R4: The fault condition is `ilim`=1 together with `fb_code`×10 < `ref_code`×7, both codes read as unsigned. Feedback at exactly 70 % does not count as a fault.
- R5: In run, the block enters off on the BLANK_CLKS-th consecutive clock edge at which the fault condition is present.
- R6: Any single clock without the fault condition during run restarts the blanking count from zero.
- R7: In off, all three shutdown outputs are 1. Off lasts OFF_TICKS ticks and then moves to restart.
- R8: The power-up, off and restart windows advance only on clock edges where `sw_tick` is 1.
- R9: Restart lasts RETRY_TICKS ticks with the three shutdown outputs at 0. The fault condition does not start blanking during restart.
- R10: On the tick that ends the restart window, the block goes to off if the fault condition is present in that cycle, and to run otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces idle asynchronously |
| sw_tick | input | 1 | One-clock pulse per switching period |
| ilim | input | 1 | Cycle-by-cycle current-limit flag |
| fb_code | input | CODE_W | Digitized feedback voltage |
| ref_code | input | CODE_W | Digitized reference voltage |
| stage_off | output | 1 | Forces both power switches off |
| comp_clamp | output | 1 | Pulls the compensation node low |
| ss_discharge | output | 1 | Discharges the soft-start node |
| state_o | output | 3 | Sequencer state code |

## Verification
A blanking count that is off by one shows up at the ports as a shutdown one clock early or one clock late. A wrong threshold compare flips the decision for the 69 %/70 % code pairs. A window counter that counts clocks instead of ticks, or that is not cleared, moves the off-to-restart or restart-to-run edge. That error is visible the same cycle the state code changes and is caught by checks placed exactly on both sides of that edge. A stuck enable path leaves the state code non-zero two time units after `en` falls.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_RUN   = 3'd2,
    ST_OFF   = 3'd3,
    ST_RETRY = 3'd4
  } hc_state_e;
endpackage

// File: rtl/hc_rst_sync.sv
module hc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/hc_uv_detect.sv
// Undervoltage-under-current-limit detector with a consecutive-clock blanking count.
module hc_uv_detect #(
  parameter int CODE_W     = 8,
  parameter int BLANK_CLKS = 3600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              ilim,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] ref_code,
  output logic              cond_o,
  output logic              trip_o
);
  localparam int PW   = CODE_W + 4;
  localparam int BW   = $clog2(BLANK_CLKS + 1);
  localparam logic [BW-1:0] LAST = BW'(BLANK_CLKS - 1);

  logic [PW-1:0] fb_x10;
  logic [PW-1:0] ref_x7;
  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_d;

  always_comb begin
    fb_x10 = PW'(fb_code) * PW'(10);
    ref_x7 = PW'(ref_code) * PW'(7);
    cond_o = ilim && (fb_x10 < ref_x7);
  end

  always_comb begin
    if (arm && cond_o) begin
      cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + BW'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign trip_o = arm && cond_o && (cnt_q == LAST);
endmodule

// File: rtl/hc_tick_timer.sv
// Window timer advanced only by the switching-cycle tick.
module hc_tick_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = tick && (cnt_q == limit - CNT_W'(1));
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
  parameter int CODE_W      = 8,
  parameter int BLANK_CLKS  = 3600,
  parameter int START_TICKS = 112,
  parameter int OFF_TICKS   = 896,
  parameter int RETRY_TICKS = 112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sw_tick,
  input  logic              ilim,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] ref_code,
  output logic              stage_off,
  output logic              comp_clamp,
  output logic              ss_discharge,
  output logic [2:0]        state_o
);
  import hiccup_pkg::*;

  localparam int MAX_A = (START_TICKS > RETRY_TICKS) ? START_TICKS : RETRY_TICKS;
  localparam int MAX_T = (OFF_TICKS > MAX_A) ? OFF_TICKS : MAX_A;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic            hold_n;
  logic            rst_sync_n;
  hc_state_e       state_q;
  hc_state_e       state_d;
  logic            arm;
  logic            cond;
  logic            trip;
  logic            timed;
  logic            win_clr;
  logic            win_done;
  logic [CNT_W-1:0] win_limit;
  logic            shut;

  assign hold_n = rst_n & en;

  hc_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (hold_n),
    .srst_n (rst_sync_n)
  );

  assign arm = (state_q == ST_RUN);

  hc_uv_detect #(
    .CODE_W     (CODE_W),
    .BLANK_CLKS (BLANK_CLKS)
  ) i_uv_detect (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .arm      (arm),
    .ilim     (ilim),
    .fb_code  (fb_code),
    .ref_code (ref_code),
    .cond_o   (cond),
    .trip_o   (trip)
  );

  always_comb begin
    case (state_q)
      ST_START: win_limit = CNT_W'(START_TICKS);
      ST_OFF:   win_limit = CNT_W'(OFF_TICKS);
      default:  win_limit = CNT_W'(RETRY_TICKS);
    endcase
  end

  assign timed   = (state_q == ST_START) || (state_q == ST_OFF) || (state_q == ST_RETRY);
  assign win_clr = !timed || (state_d != state_q);

  hc_tick_timer #(
    .CNT_W (CNT_W)
  ) i_win_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (win_clr),
    .tick  (sw_tick),
    .limit (win_limit),
    .done  (win_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  state_d = ST_START;
      ST_START: if (win_done) state_d = ST_RUN;
      ST_RUN:   if (trip) state_d = ST_OFF;
      ST_OFF:   if (win_done) state_d = ST_RETRY;
      ST_RETRY: if (win_done) state_d = cond ? ST_OFF : ST_RUN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign shut         = (state_q == ST_IDLE) || (state_q == ST_OFF);
  assign stage_off    = shut;
  assign comp_clamp   = shut;
  assign ss_discharge = shut;
  assign state_o      = state_q;
endmodule

// File: rtl/hiccup_seq_chk.sv
module hiccup_seq_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       sw_tick,
  input logic       ilim,
  input logic [2:0] state_o,
  input logic       stage_off
);
  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!srst_n)
    state_o <= 3'd4);

  assert_idle_leaves_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (state_o == 3'd0) |=> (state_o == 3'd1));

  assert_startup_no_trip_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (state_o == 3'd1) |=> (state_o == 3'd1 || state_o == 3'd2));

  assert_trip_needs_ilim_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (state_o == 3'd3 && $past(state_o) == 3'd2) |-> $past(ilim));

  assert_off_entry_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |->
      ($past(state_o) == 3'd2 || $past(state_o) == 3'd4));

  assert_shut_rise_R7: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(stage_off) |-> (state_o == 3'd3));

  assert_tick_only_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (state_o != 3'd0 && state_o != 3'd2 && !sw_tick) |=> $stable(state_o));
endmodule

bind hiccup_seq hiccup_seq_chk i_hiccup_seq_chk (
  .clk       (clk),
  .srst_n    (rst_sync_n),
  .sw_tick   (sw_tick),
  .ilim      (ilim),
  .state_o   (state_o),
  .stage_off (stage_off)
);

// File: tb/test_hiccup_seq.sv
module test_hiccup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK      = 16;
  localparam int NVEC       = 7;
  // fault-threshold vectors: fb, ref, ilim, expected state after BLANK clocks
  localparam int T_FB  [NVEC] = '{69, 70, 0, 10, 0, 178, 179};
  localparam int T_REF [NVEC] = '{100, 100, 100, 100, 0, 255, 255};
  localparam int T_IL  [NVEC] = '{1, 1, 0, 1, 1, 1, 1};
  localparam int T_EXP [NVEC] = '{3, 2, 2, 3, 2, 3, 2};

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       sw_tick;
  logic       ilim;
  logic [7:0] fb_code;
  logic [7:0] ref_code;
  logic       stage_off;
  logic       comp_clamp;
  logic       ss_discharge;
  logic [2:0] state_o;

  int checks;
  int errors;
  int cyc;

  hiccup_seq #(
    .CODE_W     (8),
    .BLANK_CLKS (BLANK)
  ) i_hiccup_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .sw_tick      (sw_tick),
    .ilim         (ilim),
    .fb_code      (fb_code),
    .ref_code     (ref_code),
    .stage_off    (stage_off),
    .comp_clamp   (comp_clamp),
    .ss_discharge (ss_discharge),
    .state_o      (state_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shut_all(string req, int exp);
    chk(req, int'(stage_off), exp);
    chk(req, int'(comp_clamp), exp);
    chk(req, int'(ss_discharge), exp);
  endtask

  task automatic power_up();
    en = 1'b0;
    clks(2);
    en = 1'b1;
    clks(115);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    cyc = 0;
    rst_n = 1'b0;
    en = 1'b1;
    sw_tick = 1'b1;
    ilim = 1'b0;
    fb_code = 8'd100;
    ref_code = 8'd100;
    clks(3);
    // R1 reset state
    chk("R1 reset state", int'(state_o), 0);
    shut_all("R1 reset outputs", 1);
    rst_n = 1'b1;

    // R3: fault held through power-up is ignored
    ilim = 1'b1;
    fb_code = 8'd0;
    en = 1'b0;
    clks(2);
    en = 1'b1;
    clks(114);
    chk("R3 still power-up", int'(state_o), 1);
    shut_all("R3 outputs low", 0);
    clks(1);
    chk("R2 R3 run after window", int'(state_o), 2);
    // R5 blanking in run
    clks(BLANK - 1);
    chk("R5 before blank end", int'(state_o), 2);
    clks(1);
    chk("R5 enter off", int'(state_o), 3);
    shut_all("R7 off outputs", 1);

    // R8 ticks only
    clks(100);
    sw_tick = 1'b0;
    clks(200);
    chk("R8 paused in off", int'(state_o), 3);
    sw_tick = 1'b1;
    clks(795);
    chk("R7 R8 off last tick", int'(state_o), 3);
    clks(1);
    chk("R7 off to restart", int'(state_o), 4);
    shut_all("R9 restart outputs", 0);
    clks(111);
    chk("R9 restart blanked", int'(state_o), 4);
    clks(1);
    chk("R10 fault persists", int'(state_o), 3);

    // R10 clean restart
    clks(896);
    chk("R7 second off ends", int'(state_o), 4);
    ilim = 1'b0;
    clks(112);
    chk("R10 return to run", int'(state_o), 2);

    // R6 blanking restart
    ilim = 1'b1;
    clks(BLANK - 1);
    ilim = 1'b0;
    clks(1);
    ilim = 1'b1;
    clks(BLANK - 1);
    chk("R6 count restarted", int'(state_o), 2);
    clks(1);
    chk("R6 trip after full run", int'(state_o), 3);

    // R1 asynchronous enable
    clks(5);
    en = 1'b0;
    #2;
    chk("R1 async idle", int'(state_o), 0);
    shut_all("R1 async outputs", 1);
    clks(3);
    chk("R1 held idle", int'(state_o), 0);
    ilim = 1'b0;
    en = 1'b1;
    clks(114);
    chk("R2 counters cleared", int'(state_o), 1);
    clks(1);
    chk("R2 run again", int'(state_o), 2);

    // R4 R5 threshold table
    for (int i = 0; i < NVEC; i++) begin
      ilim = 1'b0;
      power_up();
      chk("R2 table power-up", int'(state_o), 2);
      fb_code = 8'(T_FB[i]);
      ref_code = 8'(T_REF[i]);
      ilim = T_IL[i][0];
      clks(BLANK);
      chk("R4 R5 threshold vector", int'(state_o), T_EXP[i]);
    end

    report();
    $finish;
  end
endmodule